// File: doc/BRIEF.md
# RTC register bank with staged backup copies

This block is the register front end of a real-time clock. Software reaches it through a simple write strobe and a registered read port. The control register and the watchdog timeout register take effect at once. The seconds counter, the alarm compare value and the persistent registers live in a slow, always-on backup domain. A write to one of these lands first in a fast bus-side shadow. A single copy engine then moves the shadows into the backup domain one register at a time. A status register shows, bit by bit, which copies are still outstanding, so software can poll until the value it wrote is really in place.

The backup seconds counter advances on a once-per-second tick. When it becomes equal to the backup alarm value while alarm enable is set, a sticky alarm flag rises and drives the interrupt output through its enable. A watchdog counts down a programmed number of millisecond ticks and emits a one-cycle reset pulse when it runs out. Crystal presence is reported from two plain input pins. The copy slot length is a parameter. With the default of 16 cycles per slot, a full drain of eight registers takes 136 cycles, which is far below the 3 ms that a copy is allowed at any realistic bus clock.

Top module: `rtc_regbank`

## Requirements
- R1: After reset, every register reads 0 except the constant status bit, the stale field is 0, and `alarm_irq` and `wdog_rst` are low.
- R2: The status register (offset 0x10) has these fields:
  - bit 31 always reads 1;
  - bit 28 equals `xtal_32k0_ok` and bit 27 equals `xtal_32k768_ok`;
  - bits 23:16 are the stale flags (bit 16 is persistent 0, bits 17 to 21 are persistent 1 to 5, bit 22 is the alarm and bit 23 is seconds);
  - all other bits read 0.
- R3: A write to a staged register sets its stale flag. Reads of that register return the backup copy, which takes the new value only when the flag clears. The staged registers are seconds (0x30), alarm (0x40) and persistent n (0x60 + 0x10*n).
- R4: Pending copies are taken one at a time, and a copy already in progress finishes first. Among the remaining pending copies, the lowest stale bit goes first. Each copy takes SLOT_CYCLES+1 cycles, so eight pending copies settle within 8*(SLOT_CYCLES+1) cycles of the last write. A stale flag only ever drops when its own copy completes.
- R5: Writes to the control register use three offsets:
  - 0x00 writes the register;
  - 0x04 ORs the data into it;
  - 0x08 clears the bits written as 1.
  The writable bits are 0 (alarm interrupt enable), 1 (millisecond interrupt enable) and 4 (watchdog enable).
- R6: Persistent 0 has the same three write forms at 0x60, 0x64 and 0x68. Its bit 2 is the alarm enable. A write to +0x4 or +0x8 of any other persistent register is ignored and sets no stale flag.
- R7: Control bit 2 (the alarm flag) sets when backup seconds becomes equal to the backup alarm value while persistent 0 bit 2 is 1. `alarm_irq` is the registered AND of the flag and control bit 0.
- R8: The alarm flag is cleared only by writing 1 to bit 2 at offset 0x08. Writes to 0x00 and 0x04 leave it unchanged.
- R9: Backup seconds increments on `tick_sec`. A seconds write restarts the count from the written value when its copy completes, and ticks taken while the copy is pending are overwritten.
- R10: The watchdog works as follows:
  - it is armed while control bit 4 is 1 and the timeout register (0x50) is nonzero;
  - it loads the timeout when it becomes armed and on every write to 0x50 while armed;
  - it counts down once per `tick_ms`;
  - it pulses `wdog_rst` for one cycle when the count reaches zero;
  - clearing bit 4 stops it.
- R11: Read data appears on `bus_rdata` one cycle after the address. The low address nibble is ignored on reads, and unmapped pages read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address: page in bits 7:4, write form in bits 3:0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_sec | input | 1 | One-cycle pulse per second |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| xtal_32k0_ok | input | 1 | 32000 Hz crystal present |
| xtal_32k768_ok | input | 1 | 32768 Hz crystal present |
| alarm_irq | output | 1 | Alarm interrupt |
| wdog_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
The hardest state to reach from the ports is a queue with every stale flag set while a copy is already running, because only then do the completion order and the in-flight rule both show. The bench first writes seconds, so that its copy starts, and then writes alarm and persistent 5 down to 0 back to back inside that one slot. It then polls the status register and compares every change of the stale field with the expected drain sequence. A second hard corner is a seconds tick racing a pending seconds copy. The bench covers it by pulsing the tick right after the write and checking that the settled value is the one written.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 8;
  localparam int STALE_LSB = 16;

  localparam logic [3:0] PG_CTRL = 4'h0;
  localparam logic [3:0] PG_STAT = 4'h1;
  localparam logic [3:0] PG_SEC  = 4'h3;
  localparam logic [3:0] PG_ALM  = 4'h4;
  localparam logic [3:0] PG_WDG  = 4'h5;
  localparam logic [3:0] PG_P0   = 4'h6;

  localparam logic [3:0] AL_BASE = 4'h0;
  localparam logic [3:0] AL_SET  = 4'h4;
  localparam logic [3:0] AL_CLR  = 4'h8;

  localparam int CTRL_ALM_IE = 0;
  localparam int CTRL_ALM_FL = 2;
  localparam int CTRL_WD_EN  = 4;
  localparam logic [REG_W-1:0] CTRL_WMASK = 32'h0000_0013;
  localparam int P0_ALM_EN = 2;

  // Plain write, OR-in, or AND-NOT depending on the low address nibble.
  function automatic logic [REG_W-1:0] alias_apply(
      input logic [REG_W-1:0] old, input logic [REG_W-1:0] wd, input logic [3:0] al);
    case (al)
      AL_BASE: return wd;
      AL_SET:  return old | wd;
      AL_CLR:  return old & ~wd;
      default: return old;
    endcase
  endfunction
endpackage

// File: rtl/rtc_stage_seq.sv
`timescale 1ns/1ps
module rtc_stage_seq #(
  parameter int NREG = 8,
  parameter int SLOT = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NREG-1:0]         mark,
  output logic [NREG-1:0]         stale,
  output logic                    fire,
  output logic [$clog2(NREG)-1:0] cur_idx
);
  localparam int IW = $clog2(NREG);
  localparam int CW = (SLOT > 1) ? $clog2(SLOT) : 1;

  logic          busy;
  logic [CW-1:0] cnt;
  logic [IW-1:0] pick;
  logic [NREG-1:0] cur_oh, drop;

  always_comb begin
    pick = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (stale[i]) pick = IW'(i);
  end

  assign fire   = busy && (cnt == CW'(SLOT - 1));
  assign cur_oh = NREG'(1) << cur_idx;
  assign drop   = fire ? (cur_oh & ~mark) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      stale   <= '0;
      busy    <= 1'b0;
      cnt     <= '0;
      cur_idx <= '0;
    end else begin
      stale <= (stale | mark) & ~drop;
      if (!busy) begin
        if (|stale) begin
          busy    <= 1'b1;
          cur_idx <= pick;
          cnt     <= '0;
        end
      end else if (fire) begin
        busy <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_wdog.sv
`timescale 1ns/1ps
module rtc_wdog #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] timeout,
  input  logic         reload,
  input  logic         tick,
  output logic         bite
);
  logic         armed, arm_q;
  logic [W-1:0] cnt;

  assign armed = en && (|timeout);

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q <= 1'b0;
      cnt   <= '0;
      bite  <= 1'b0;
    end else begin
      arm_q <= armed;
      bite  <= 1'b0;
      if (!armed) begin
        cnt <= '0;
      end else if (!arm_q || reload) begin
        cnt <= timeout;
      end else if (tick && (cnt != '0)) begin
        cnt <= cnt - 1'b1;
        if (cnt == W'(1)) bite <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_regbank.sv
`timescale 1ns/1ps
module rtc_regbank
  import rtc_pkg::*;
#(
  parameter int SLOT_CYCLES = 16,
  parameter int NPERS       = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              tick_sec,
  input  logic              tick_ms,
  input  logic              xtal_32k0_ok,
  input  logic              xtal_32k768_ok,
  output logic              alarm_irq,
  output logic              wdog_rst
);
  localparam int NSTG    = NPERS + 2;
  localparam int IW      = $clog2(NSTG);
  localparam int IDX_ALM = NPERS;
  localparam int IDX_SEC = NPERS + 1;

  logic [3:0] pg, al;
  assign pg = bus_addr[7:4];
  assign al = bus_addr[3:0];

  logic [NSTG-1:0]  mark, stale;
  logic             fire;
  logic [IW-1:0]    cur_idx;
  logic [REG_W-1:0] shd [NSTG];
  logic [REG_W-1:0] bk  [NSTG];

  // Write decode for each staged register; only persistent 0 accepts the OR/AND-NOT forms.
  for (genvar g = 0; g < NSTG; g++) begin : g_mark
    localparam logic [3:0] PG = (g < NPERS) ? 4'(PG_P0 + g) :
                                (g == IDX_ALM) ? PG_ALM : PG_SEC;
    assign mark[g] = bus_we && (pg == PG) &&
                     ((al == AL_BASE) || ((g == 0) && ((al == AL_SET) || (al == AL_CLR))));
  end

  rtc_stage_seq #(.NREG(NSTG), .SLOT(SLOT_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .mark(mark), .stale(stale), .fire(fire), .cur_idx(cur_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSTG; i++) begin
        shd[i] <= '0;
        bk[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NSTG; i++) begin
        if (mark[i]) shd[i] <= alias_apply(shd[i], bus_wdata, al);
        if (fire && (cur_idx == IW'(i)))           bk[i] <= shd[i];
        else if ((i == IDX_SEC) && tick_sec)       bk[i] <= bk[i] + 1'b1;
      end
    end
  end

  logic [REG_W-1:0] ctrl_q, wdg_q;
  logic alm_flag, match_q, wdg_wr_q;
  logic ctrl_hit, alm_clr_hit, wdg_hit, match;

  assign ctrl_hit    = bus_we && (pg == PG_CTRL);
  assign alm_clr_hit = ctrl_hit && (al == AL_CLR) && bus_wdata[CTRL_ALM_FL];
  assign wdg_hit     = bus_we && (pg == PG_WDG) && (al == AL_BASE);
  assign match       = (bk[IDX_SEC] == bk[IDX_ALM]) && bk[0][P0_ALM_EN];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      wdg_q     <= '0;
      alm_flag  <= 1'b0;
      match_q   <= 1'b0;
      wdg_wr_q  <= 1'b0;
      alarm_irq <= 1'b0;
    end else begin
      if (ctrl_hit) ctrl_q <= alias_apply(ctrl_q, bus_wdata, al) & CTRL_WMASK;
      match_q <= match;
      if (match && !match_q) alm_flag <= 1'b1;
      else if (alm_clr_hit)  alm_flag <= 1'b0;
      if (wdg_hit) wdg_q <= bus_wdata;
      wdg_wr_q  <= wdg_hit;
      alarm_irq <= alm_flag && ctrl_q[CTRL_ALM_IE];
    end
  end

  rtc_wdog #(.W(REG_W)) u_wdog (
    .clk(clk), .rst(rst), .en(ctrl_q[CTRL_WD_EN]), .timeout(wdg_q),
    .reload(wdg_wr_q), .tick(tick_ms), .bite(wdog_rst)
  );

  logic [REG_W-1:0] stat_v, rd_mux;
  always_comb begin
    stat_v = '0;
    stat_v[31] = 1'b1;
    stat_v[28] = xtal_32k0_ok;
    stat_v[27] = xtal_32k768_ok;
    stat_v[STALE_LSB +: NSTG] = stale;
  end

  always_comb begin
    rd_mux = '0;
    case (pg)
      PG_CTRL: begin
        rd_mux = ctrl_q;
        rd_mux[CTRL_ALM_FL] = alm_flag;
      end
      PG_STAT: rd_mux = stat_v;
      PG_SEC:  rd_mux = bk[IDX_SEC];
      PG_ALM:  rd_mux = bk[IDX_ALM];
      PG_WDG:  rd_mux = wdg_q;
      default: begin
        for (int i = 0; i < NPERS; i++)
          if (pg == 4'(PG_P0 + i)) rd_mux = bk[i];
      end
    endcase
  end

  always_ff @(posedge clk) bus_rdata <= rd_mux;
endmodule

// File: rtl/rtc_regbank_chk.sv
`timescale 1ns/1ps
module rtc_regbank_chk #(
  parameter int NSTG = 8,
  parameter int IW   = 3
) (
  input logic            clk,
  input logic            rst,
  input logic [NSTG-1:0] stale,
  input logic            fire,
  input logic [IW-1:0]   cur_idx,
  input logic            alm_flag,
  input logic            irq_en,
  input logic            alm_clr_hit,
  input logic            alarm_irq,
  input logic            wdog_rst,
  input logic [7:0]      bus_addr,
  input logic [31:0]     bus_rdata
);
  AST_STAT_PRESENT: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr[7:4]) == 4'h1) |-> bus_rdata[31]); // R2

  AST_STALE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fire |=> ((stale & $past(stale)) == $past(stale))); // R3

  AST_FIRE_PENDING: assert property (@(posedge clk) disable iff (rst)
    fire |-> stale[cur_idx]); // R4

  AST_SINGLE_DROP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones($past(stale) & ~stale) <= 1)); // R4

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    alarm_irq |-> $past(alm_flag && irq_en)); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (alm_flag && !alm_clr_hit) |=> alm_flag); // R8

  AST_WDOG_PULSE: assert property (@(posedge clk) disable iff (rst)
    wdog_rst |=> !wdog_rst); // R10
endmodule

bind rtc_regbank rtc_regbank_chk #(.NSTG(NSTG), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .stale(stale), .fire(fire), .cur_idx(cur_idx),
  .alm_flag(alm_flag), .irq_en(ctrl_q[0]), .alm_clr_hit(alm_clr_hit),
  .alarm_irq(alarm_irq), .wdog_rst(wdog_rst), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/tb_rtc_regbank.sv
`timescale 1ns/1ps
module tb_rtc_regbank;
  localparam int SLOT = 16;
  localparam logic [7:0] A_CTRL = 8'h00, A_STAT = 8'h10, A_SEC = 8'h30,
                         A_ALM = 8'h40, A_WDG = 8'h50, A_P0 = 8'h60, A_P1 = 8'h70;

  logic clk = 1'b0, rst = 1'b1, bus_we = 1'b0, tick_sec = 1'b0, tick_ms = 1'b0;
  logic x0 = 1'b0, x1 = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic alarm_irq, wdog_rst;

  always #2.5 clk = ~clk;

  rtc_regbank #(.SLOT_CYCLES(SLOT), .NPERS(6)) dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tick_sec(tick_sec), .tick_ms(tick_ms),
    .xtal_32k0_ok(x0), .xtal_32k768_ok(x1), .alarm_irq(alarm_irq), .wdog_rst(wdog_rst)
  );

  int n_chk = 0, n_fail = 0, pulses = 0;
  bit done = 0;

  always @(negedge clk) if (!rst && wdog_rst) pulses++;

  function automatic logic [31:0] amodel(logic [31:0] old, logic [31:0] wd, logic [3:0] al);
    if (al == 4'h0) return wd;
    if (al == 4'h4) return old | wd;
    if (al == 4'h8) return old & ~wd;
    return old;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0; bus_addr = 8'h00;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a;
    @(posedge clk);
    @(negedge clk); d = bus_rdata; bus_addr = 8'h00;
  endtask

  task automatic settle();
    logic [31:0] s;
    for (int k = 0; k < 400; k++) begin
      rd(A_STAT, s);
      if (s[23:16] == 8'h00) return;
    end
    chk("R4 settle timeout", {24'h0, s[23:16]}, 32'h0);
  endtask

  task automatic tk_s(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_sec = 1'b1;
      @(negedge clk); tick_sec = 1'b0;
    end
  endtask

  task automatic tk_m(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_ms = 1'b1;
      @(negedge clk); tick_ms = 1'b0;
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, m[6];
    logic [7:0] ord[8], prev, f;
    int idx, cyc, p0;
    void'($urandom(32'd4242));
    ord = '{8'h7F, 8'h7E, 8'h7C, 8'h78, 8'h70, 8'h60, 8'h40, 8'h00};
    for (int i = 0; i < 6; i++) m[i] = '0;
    idle(4); rst = 1'b0; idle(2);

    // R1 reset state
    rd(A_STAT, d); chk("R1 stat", d, 32'h8000_0000);
    rd(A_CTRL, d); chk("R1 ctrl", d, 32'h0);
    rd(A_SEC, d);  chk("R1 seconds", d, 32'h0);
    rd(A_P0, d);   chk("R1 pers0", d, 32'h0);
    chk("R1 outputs", {30'h0, alarm_irq, wdog_rst}, 32'h0);

    // R2 crystal bits
    x0 = 1'b1; rd(A_STAT, d); chk("R2 xtal32000", d, 32'h9000_0000);
    x0 = 1'b0; x1 = 1'b1; rd(A_STAT, d); chk("R2 xtal32768", d, 32'h8800_0000);
    x1 = 1'b0;

    // R11 unmapped page and read nibble ignored
    rd(8'h20, d); chk("R11 unmapped", d, 32'h0);

    // R3 staged write
    wr(A_P1, 32'hA5A5_0001); m[1] = 32'hA5A5_0001;
    rd(A_P1, d);   chk("R3 old value while stale", d, 32'h0);
    rd(A_STAT, d); chk("R3 stale bit", {24'h0, d[23:16]}, 32'h02);
    settle();
    rd(A_P1, d);   chk("R3 new value after copy", d, 32'hA5A5_0001);

    // R6 alias on persistent 1 is ignored
    wr(A_P1 + 8'h4, 32'hFFFF_FFFF);
    rd(A_STAT, d); chk("R6 no stale on P1 alias", {24'h0, d[23:16]}, 32'h0);
    idle(40);
    rd(A_P1, d);   chk("R6 P1 unchanged", d, 32'hA5A5_0001);

    // R5 control aliases
    wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, d); chk("R5 base mask", d, 32'h13);
    wr(A_CTRL + 8'h8, 32'h2);  rd(A_CTRL + 8'hC, d); chk("R5 clear alias", d, 32'h11);
    wr(A_CTRL, 32'h0);         rd(A_CTRL, d); chk("R5 base zero", d, 32'h0);
    wr(A_CTRL + 8'h4, 32'h12); rd(A_CTRL, d); chk("R5 set alias", d, 32'h12);
    wr(A_CTRL, 32'h0);

    // R6 persistent 0 aliases
    wr(A_P0, 32'h30); wr(A_P0 + 8'h4, 32'h81); wr(A_P0 + 8'h8, 32'h10);
    m[0] = 32'hA1;
    settle();
    rd(A_P0, d); chk("R6 pers0 alias result", d, 32'hA1);

    // R4 drain order: seconds copy starts first, then the rest stack up
    wr(A_SEC, 32'h1); wr(A_ALM, 32'h2);
    for (int i = 5; i >= 0; i--) begin
      wr(A_P0 + 8'(i * 16), 32'(i + 8));
      m[i] = 32'(i + 8);
    end
    rd(A_STAT, d); chk("R4 all pending", {24'h0, d[23:16]}, 32'hFF);
    prev = 8'hFF; idx = 0; cyc = 0;
    while (idx < 8 && cyc < 600) begin
      rd(A_STAT, d); cyc += 2; f = d[23:16];
      if (f != prev) begin
        chk("R4 drain step", {24'h0, f}, {24'h0, ord[idx]});
        idx++; prev = f;
      end
    end
    chk("R4 latency bound", 32'(cyc <= 8 * (SLOT + 1) + 4), 32'h1);
    rd(A_SEC, d); chk("R3 seconds copied", d, 32'h1);
    rd(A_ALM, d); chk("R3 alarm copied", d, 32'h2);

    // Random persistent traffic against a model
    for (int r = 0; r < 6; r++) begin
      for (int k = 0; k < 6; k++) begin
        int i;
        logic [3:0] al;
        logic [31:0] v;
        i = int'($urandom % 6);
        v = $urandom;
        al = 4'h0;
        if (i == 0) begin
          p0 = int'($urandom % 3);
          al = (p0 == 0) ? 4'h0 : (p0 == 1) ? 4'h4 : 4'h8;
        end
        wr(A_P0 + 8'(i * 16) + {4'h0, al}, v);
        m[i] = amodel(m[i], v, al);
      end
      settle();
      for (int i = 0; i < 6; i++) begin
        rd(A_P0 + 8'(i * 16), d);
        chk("R3 random persistent readback", d, m[i]);
      end
    end

    // R9 seconds restart with ticks racing the copy
    wr(A_SEC, 32'd500); tk_s(3); settle();
    rd(A_SEC, d); chk("R9 restart value", d, 32'd500);
    tk_s(2); idle(2);
    rd(A_SEC, d); chk("R9 counting", d, 32'd502);

    // R7 alarm
    wr(A_ALM, 32'd505); wr(A_P0 + 8'h4, 32'h4); wr(A_CTRL, 32'h1); settle();
    wr(A_CTRL + 8'h8, 32'h4);
    rd(A_CTRL, d); chk("R7 flag clear before match", d, 32'h1);
    tk_s(3); idle(4);
    rd(A_CTRL, d); chk("R7 flag set on match", d, 32'h5);
    chk("R7 irq asserted", {31'h0, alarm_irq}, 32'h1);

    // R8 sticky flag
    wr(A_CTRL, 32'h1); wr(A_CTRL + 8'h4, 32'h0);
    rd(A_CTRL, d); chk("R8 base write keeps flag", d, 32'h5);
    wr(A_CTRL + 8'h8, 32'h4); idle(2);
    rd(A_CTRL, d); chk("R8 clear alias", d, 32'h1);
    chk("R8 irq drops", {31'h0, alarm_irq}, 32'h0);

    // R7 no flag when alarm enable is off
    wr(A_P0 + 8'h8, 32'h4); settle();
    wr(A_SEC, 32'd505); settle(); idle(4);
    rd(A_CTRL, d); chk("R7 disabled alarm", d, 32'h1);
    wr(A_CTRL, 32'h0);

    // R10 watchdog
    wr(A_WDG, 32'd5); wr(A_CTRL + 8'h4, 32'h10); idle(3);
    tk_m(4); idle(3); chk("R10 no bite early", 32'(pulses), 32'd0);
    tk_m(1); idle(3); chk("R10 bite", 32'(pulses), 32'd1);
    tk_m(3); idle(3); chk("R10 single bite", 32'(pulses), 32'd1);
    wr(A_CTRL + 8'h8, 32'h10); wr(A_WDG, 32'd3); wr(A_CTRL + 8'h4, 32'h10); idle(3);
    tk_m(2); wr(A_WDG, 32'd3); idle(3);
    tk_m(2); idle(3); chk("R10 reload delays bite", 32'(pulses), 32'd1);
    tk_m(1); idle(3); chk("R10 bite after reload", 32'(pulses), 32'd2);
    wr(A_CTRL + 8'h8, 32'h10); wr(A_CTRL + 8'h4, 32'h10); idle(3);
    tk_m(2); wr(A_CTRL + 8'h8, 32'h10); tk_m(5); idle(3);
    chk("R10 disable stops", 32'(pulses), 32'd2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule